// File: doc/BRIEF.md
# Grouped Output Enable Controller

This block sits between a pattern sequencer and the channel drivers of a parallel test port. On every cycle it decides, for each channel, the value presented to the driver and whether that driver is enabled. Channels are organised in fixed groups of eight. The enable for a group is the conjunction of three sources: a per-step control bit that arrives with each pattern step, a host configuration bit, and an external enable pin. The host and external sources act directly on the outputs in the same cycle, so a group can be tri-stated at any time, even during a run.

The port has one direction for all of its channels, input or output. The direction can be rewritten only while the sequencer is halted, and writes made during a run are dropped. When the port is set to input, no channel drives. Each pattern step that arrives during a run is captured together with its group enables. After a halt, a 2-bit mode chooses what the outputs do: keep driving the captured vector, release every driver, or drive zeros.

Top module: `grouped_oe_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every output enable is low, the data bus is zero, and the direction is input.
- R2: Channel c belongs to group c/8, so the groups are 0–7, 8–15, 16–23 and 24–31. All channels of a group always have the same enable value.
- R3: While `run` is high, a cycle with `step_valid` high captures `pat_data` and `step_grp_en`, and they appear on `dout` and are used for the enables after that clock edge. When `run` is low, `step_valid` has no effect on the captured vector.
- R4: While running, the enable of group g is `dir_is_out AND step_en_q[g] AND host_grp_en[g] AND ext_grp_en[g]`, where `step_en_q` holds the step enables of the most recent captured step.
- R5: When `host_grp_en[g]` or `ext_grp_en[g]` is deasserted, group g stops driving in the same cycle. This applies whether or not the block is running.
- R6: When `dir_wr` is high and `run` is low, the direction takes the value of `dir_val` (1 = output, 0 = input) after the clock edge. A `dir_wr` while `run` is high is ignored.
- R7: While the direction is input, all 32 output enables are low, whatever the group enable settings.
- R8: When halted with `halt_mode` = 00 (hold), `dout` keeps showing the last captured vector. The enables follow the R4 expression, using the last captured step enables.
- R9: When halted with `halt_mode` = 01 (tri-state), all output enables are low and `dout` keeps the last captured vector.
- R10: When halted with `halt_mode` = 10 (zero), `dout` is all zeros. The enable of group g is `dir_is_out AND host_grp_en[g] AND ext_grp_en[g]`.
- R11: When halted, `halt_mode` = 11 behaves exactly like 00 (hold).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | 1 = sequencer running, 0 = halted |
| step_valid | input | 1 | A generator step occurs in this cycle |
| pat_data | input | 32 | Pattern vector of the current step |
| step_grp_en | input | 4 | Per-step group enables of the current step |
| host_grp_en | input | 4 | Host register group enables |
| ext_grp_en | input | 4 | External group enable pins |
| halt_mode | input | 2 | Halt behaviour: 00 hold, 01 tri-state, 10 zero, 11 hold |
| dir_wr | input | 1 | Direction write strobe |
| dir_val | input | 1 | Direction to write: 1 output, 0 input |
| dout | output | 32 | Data presented to the channel drivers |
| doe | output | 32 | Per-channel driver enables |

## Verification
The bench uses the default build of 32 channels in groups of eight. This gives four enable groups, so any single group can be cut while its neighbours keep driving, and a wrong group boundary shows up as a mismatch at a channel next to a byte edge. Random step patterns, host masks and external masks are applied while running and then under each of the four halt codes. Direction writes are issued both during a run and during a halt, so the lock on the direction can be seen on the enables.

// File: rtl/goe_pkg.sv
// Package goe_pkg
// Shared encoding for the halt behaviour selector of the grouped output
// enable controller. Assumes the selector is a 2-bit host field.
package goe_pkg;
    typedef enum logic [1:0] {
        HM_HOLD = 2'b00,
        HM_TRI  = 2'b01,
        HM_ZERO = 2'b10,
        HM_ALT  = 2'b11
    } halt_mode_e;
endpackage

// File: rtl/goe_dir_lock.sv
// Module goe_dir_lock
// Holds the port direction (1 = output). The direction can be rewritten only
// while the sequencer is halted. Assumes run and dir_wr are synchronous to clk.
module goe_dir_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic dir_wr,
    input  logic dir_val,
    output logic dir_q
);
    // Direction register: it takes a write only in the halt state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= 1'b0;
        else if (dir_wr && !run)
            dir_q <= dir_val;
    end

    // R6: a write during a run leaves the direction unchanged
    p_dir_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dir_wr) |=> $stable(dir_q));
endmodule

// File: rtl/goe_vec_hold.sv
// Module goe_vec_hold
// Captures the pattern vector and the per-step group enables on each step
// during a run, so that they keep being driven, or can be replayed, after a
// halt. Assumes step_valid is a one-cycle strobe for each step.
module goe_vec_hold #(
    parameter int CH_W  = 32,
    parameter int N_GRP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step_valid,
    input  logic [CH_W-1:0]  pat_data,
    input  logic [N_GRP-1:0] step_grp_en,
    output logic [CH_W-1:0]  last_vec,
    output logic [N_GRP-1:0] step_en_q
);
    logic capture;

    // A step counts only while running.
    always_comb capture = run && step_valid;

    // Vector and step-enable registers, loaded on each counted step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_vec  <= '0;
            step_en_q <= '0;
        end else if (capture) begin
            last_vec  <= pat_data;
            step_en_q <= step_grp_en;
        end
    end

    // R3: steps offered while halted do not disturb the held vector
    p_halt_keeps_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(last_vec));
endmodule

// File: rtl/goe_grp_drive.sv
// Module goe_grp_drive
// Output stage for one group of channels. It chooses the data and the single
// group enable from the run state, the halt mode and the three enable
// sources. Purely combinational. Assumes mode is only used while halted.
module goe_grp_drive
    import goe_pkg::*;
#(
    parameter int GRP_W = 8
) (
    input  logic             run,
    input  halt_mode_e       mode,
    input  logic             dir_out,
    input  logic             step_en,
    input  logic             host_en,
    input  logic             ext_en,
    input  logic [GRP_W-1:0] vec,
    output logic [GRP_W-1:0] d,
    output logic [GRP_W-1:0] oe
);
    logic live_en;
    logic grp_en;

    // Enable sources that act at once, whatever the run state.
    always_comb live_en = dir_out && host_en && ext_en;

    // Pick the group enable and the data from the run state and the halt mode.
    always_comb begin
        grp_en = live_en && step_en;
        d      = vec;
        if (!run) begin
            unique case (mode)
                HM_TRI:  grp_en = 1'b0;
                HM_ZERO: begin
                    grp_en = live_en;
                    d      = '0;
                end
                default: grp_en = live_en && step_en;
            endcase
        end
    end

    // Fan the group enable out to every channel of the group.
    always_comb oe = {GRP_W{grp_en}};
endmodule

// File: rtl/grouped_oe_ctrl.sv
// Module grouped_oe_ctrl
// Top of the grouped output enable controller. It splits the channel bus into
// fixed groups, gates each group with step, host and external enables,
// applies the direction lock, and applies the halt behaviour.
// Assumes CH_W is a multiple of GRP_W.
module grouped_oe_ctrl
    import goe_pkg::*;
#(
    parameter  int CH_W  = 32,
    parameter  int GRP_W = 8,
    localparam int N_GRP = CH_W / GRP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step_valid,
    input  logic [CH_W-1:0]  pat_data,
    input  logic [N_GRP-1:0] step_grp_en,
    input  logic [N_GRP-1:0] host_grp_en,
    input  logic [N_GRP-1:0] ext_grp_en,
    input  logic [1:0]       halt_mode,
    input  logic             dir_wr,
    input  logic             dir_val,
    output logic [CH_W-1:0]  dout,
    output logic [CH_W-1:0]  doe
);
    logic             dir_q;
    logic [CH_W-1:0]  last_vec;
    logic [N_GRP-1:0] step_en_q;
    halt_mode_e       mode;

    // Decode the host halt-mode field.
    always_comb mode = halt_mode_e'(halt_mode);

    goe_dir_lock u_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .dir_wr  (dir_wr),
        .dir_val (dir_val),
        .dir_q   (dir_q)
    );

    goe_vec_hold #(.CH_W(CH_W), .N_GRP(N_GRP)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .step_valid  (step_valid),
        .pat_data    (pat_data),
        .step_grp_en (step_grp_en),
        .last_vec    (last_vec),
        .step_en_q   (step_en_q)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        goe_grp_drive #(.GRP_W(GRP_W)) u_drv (
            .run     (run),
            .mode    (mode),
            .dir_out (dir_q),
            .step_en (step_en_q[g]),
            .host_en (host_grp_en[g]),
            .ext_en  (ext_grp_en[g]),
            .vec     (last_vec[g*GRP_W +: GRP_W]),
            .d       (dout[g*GRP_W +: GRP_W]),
            .oe      (doe[g*GRP_W +: GRP_W])
        );

        // R2: a group's channels always agree on their enable
        p_group_uniform_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(doe[g*GRP_W +: GRP_W]) == 0) ||
            ($countones(doe[g*GRP_W +: GRP_W]) == GRP_W));

        // R5: dropping the host or the external enable releases the group
        p_live_cut_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!host_grp_en[g] || !ext_grp_en[g]) |-> (doe[g*GRP_W +: GRP_W] == '0));
    end

    // R7: input direction never drives
    p_input_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_q |-> (doe == '0));

    // R9: tri-state halt releases every driver
    p_tristate_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && halt_mode == 2'b01) |-> (doe == '0));

    // R10: zero halt drives a zero bus
    p_zero_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && halt_mode == 2'b10) |-> (dout == '0));
endmodule

// File: tb/tb_grouped_oe_ctrl.sv
module tb_grouped_oe_ctrl;
    localparam int CH_W  = 32;
    localparam int GRP_W = 8;
    localparam int NG    = CH_W / GRP_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            run = 1'b0;
    logic            step_valid = 1'b0;
    logic [CH_W-1:0] pat_data = '0;
    logic [NG-1:0]   step_grp_en = '0;
    logic [NG-1:0]   host_grp_en = '1;
    logic [NG-1:0]   ext_grp_en = '1;
    logic [1:0]      halt_mode = 2'b00;
    logic            dir_wr = 1'b0;
    logic            dir_val = 1'b0;
    logic [CH_W-1:0] dout;
    logic [CH_W-1:0] doe;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    // Reference state, kept behaviourally.
    bit            m_dir;
    bit [CH_W-1:0] m_vec;
    bit [NG-1:0]   m_sten;

    always #5 clk = ~clk;

    grouped_oe_ctrl dut (
        .clk(clk), .rst_n(rst_n), .run(run), .step_valid(step_valid),
        .pat_data(pat_data), .step_grp_en(step_grp_en),
        .host_grp_en(host_grp_en), .ext_grp_en(ext_grp_en),
        .halt_mode(halt_mode), .dir_wr(dir_wr), .dir_val(dir_val),
        .dout(dout), .doe(doe)
    );

    // One clock: advance the model at the edge, then compare the outputs.
    task automatic cyc(input string req);
        bit [CH_W-1:0] e_d;
        bit [CH_W-1:0] e_oe;
        @(posedge clk);
        if (!rst_n) begin
            m_dir = 0; m_vec = '0; m_sten = '0;
        end else begin
            if (!run && dir_wr) m_dir = dir_val;
            if (run && step_valid) begin
                m_vec  = pat_data;
                m_sten = step_grp_en;
            end
        end
        #1;
        e_d = m_vec;
        e_oe = '0;
        for (int c = 0; c < CH_W; c++) begin
            bit live;
            live = m_dir && host_grp_en[c/GRP_W] && ext_grp_en[c/GRP_W];
            if (run || halt_mode == 2'b00 || halt_mode == 2'b11)
                e_oe[c] = live && m_sten[c/GRP_W];
            else if (halt_mode == 2'b10) begin
                e_oe[c] = live;
                e_d[c]  = 1'b0;
            end
        end
        n_checks++;
        if (dout !== e_d || doe !== e_oe) begin
            n_fails++;
            $display("FAIL %s: dout=%h doe=%h expected dout=%h doe=%h",
                     req, dout, doe, e_d, e_oe);
        end
    endtask

    task automatic rnd_step();
        pat_data    = $urandom;
        step_valid  = ($urandom % 3) != 0;
        step_grp_en = 4'($urandom);
    endtask

    initial begin
        // R1: reset state
        repeat (3) cyc("R1");
        rst_n = 1'b1;
        cyc("R1");
        // R6: direction write while halted
        dir_wr = 1; dir_val = 1;
        cyc("R6");
        dir_wr = 0;
        // R3: steps while halted are ignored
        pat_data = 32'hDEAD_BEEF; step_valid = 1; step_grp_en = '1;
        cyc("R3");
        cyc("R3");
        // R2: single-group steps during run
        run = 1;
        for (int g = 0; g < NG; g++) begin
            pat_data = 32'hFFFF_FFFF; step_valid = 1; step_grp_en = 4'(1 << g);
            cyc("R2");
        end
        // R4: random run traffic
        for (int i = 0; i < 60; i++) begin
            rnd_step();
            host_grp_en = ($urandom % 4 == 0) ? 4'($urandom) : '1;
            ext_grp_en  = ($urandom % 4 == 0) ? 4'($urandom) : '1;
            cyc("R4");
        end
        // R6: direction write during run is ignored
        host_grp_en = '1; ext_grp_en = '1;
        pat_data = 32'h1234_5678; step_valid = 1; step_grp_en = '1;
        cyc("R6");
        step_valid = 0;
        dir_wr = 1; dir_val = 0;
        repeat (3) cyc("R6");
        dir_wr = 0;
        // R5: live cuts during run
        host_grp_en = 4'b1011; cyc("R5");
        ext_grp_en  = 4'b1110; cyc("R5");
        host_grp_en = '1; ext_grp_en = '1; cyc("R5");
        // Halt modes R8..R11
        run = 0;
        halt_mode = 2'b00;
        for (int i = 0; i < 8; i++) begin rnd_step(); cyc("R8"); end
        halt_mode = 2'b01;
        for (int i = 0; i < 8; i++) begin rnd_step(); cyc("R9"); end
        halt_mode = 2'b10;
        for (int i = 0; i < 8; i++) begin
            rnd_step(); host_grp_en = 4'($urandom); cyc("R10");
        end
        halt_mode = 2'b11; host_grp_en = '1;
        for (int i = 0; i < 8; i++) begin
            rnd_step(); ext_grp_en = 4'($urandom); cyc("R11");
        end
        ext_grp_en = '1;
        // R5: live cut while halted
        halt_mode = 2'b00; host_grp_en = 4'b0111; cyc("R5");
        host_grp_en = '1;
        // R7: input direction forces enables low
        dir_wr = 1; dir_val = 0; cyc("R7");
        dir_wr = 0;
        halt_mode = 2'b10; cyc("R7");
        run = 1;
        for (int i = 0; i < 10; i++) begin rnd_step(); cyc("R7"); end
        // R1: reset mid-run
        rst_n = 0; cyc("R1");
        rst_n = 1; step_valid = 0; cyc("R1");
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule